// File: doc/BRIEF.md
# Double-Buffered Byte Serial Port (SPI)

This block is a byte-wide SPI port for a CPU register bus. In master mode it generates the serial clock from the system clock through a programmable divider. In slave mode it takes the serial clock from a pin, with an optional active-low select input. The clock, select and slave data inputs pass through a two-flop synchronizer.

Every transfer moves exactly eight bits, most significant first, through an internal shift engine that the CPU cannot reach. All data goes through one data register. A CPU write to that register while the port is idle loads the engine, and in master mode it also starts the transfer. A CPU read of that register returns the last completed receive byte.

When a transfer finishes, the received byte is copied into the data register. A full flag and an interrupt flag are set at the same edge. Because of this buffering, the next byte can shift while the previous byte is still unread. A write made while a transfer is running is dropped and sets a sticky collision flag.

The bus has three registers, chosen by `bus_addr`:
- **Data (0):** write loads the transmit byte; read returns the received byte.
- **Control (1):**
  - bit 0: master
  - bit 1: clock idle level
  - bit 2: output changes on the leading edge
  - bit 3: late sample (master only)
  - bits 5:4: rate
  - bit 6: select enable (slave only)
- **Status (2):**
  - bit 0: full
  - bit 1: collision
  - bit 2: interrupt
  - bit 3: busy
  - A write of 1 to bit 1 clears the collision flag. A write of 1 to bit 2 clears the interrupt flag.

Top module: `spi_port`

## Requirements
- R1: In master mode, a data write while idle loads the byte and starts a transfer. Eight bits leave on `sdo_o` most significant first. The eight bits sampled from `sdi_i` are assembled most significant first and returned by a data read.
- R2: The master serial clock rests at control bit 1 when idle. After the start write it makes 16 toggles, each H system cycles apart, with H = 2, 8, 32, 128 for rate 0, 1, 2, 3. The first toggle is H cycles after the write edge.
- R3: With control bit 2 clear, bit k (k≥1) appears after toggle 2k and is sampled at toggle 2k+1. With bit 2 set, bit k appears after toggle 2k+1 and is sampled at toggle 2k+2.
- R4: In master mode, control bit 3 set moves each sample one half period later. When bit 2 is also set, this adds one trailing half period before completion.
- R5: At completion, status bit 0 and bit 2 and the `irq` pin are set at the same edge as the receive byte is copied into the data register. Status bit 3 drops at that edge.
- R6: A data read with `bus_rd` high clears status bit 0.
- R7: A data write while status bit 3 is set changes neither the transfer nor the transmitted bits, and sets status bit 1.
- R8: Status bit 1 stays set until a status write with bit 1 high. Status bit 2 clears on a status write with bit 2 high.
- R9: A new transfer may start while status bit 0 is still set, without a collision. Its result replaces the unread byte.
- R10: In slave mode, `sck_oe` is low. Edges on `sck_i` shift the byte: samples on leading edges, output changes on trailing edges (bit 2 clear). The byte completes on the 16th edge.
- R11: In slave mode with control bit 6 set, a high `ss_n_i` drives `sdo_oe` low and resets the bit count. Status bit 3 drops, and the next data write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears full on data read) |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Interrupt flag |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock drive enable |
| sck_i | input | 1 | Serial clock in (slave) |
| ss_n_i | input | 1 | Active-low slave select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data drive enable |

## Verification
In master mode, busy rises at the write edge, and clock toggle t lands exactly t·H edges later. Completion comes 16·H edges after the write, or 17·H when a late sample follows leading-edge output. The full, interrupt and receive-byte results are due at that edge. The bench counts edges since the write edge and compares the clock level on every cycle. It checks `sdo_o` on the cycle just before each sampling edge and drives `sdi_i` one cycle ahead of it. Flags are read on the cycle after completion, and the collision flag on the cycle after the offending write. Slave pins cross a two-flop synchronizer plus an edge register, so slave checks are made a full half-period after each external edge, and completion is read six cycles after the last edge.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_DATA = 2'd0,
        RA_CTRL = 2'd1,
        RA_STAT = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    // Control word as stored; bit 0 is the LSB of the bus word.
    typedef struct packed {
        logic       sel_en;
        logic [1:0] rate;
        logic       late_smp;
        logic       out_lead;
        logic       cpol;
        logic       master;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic irq;
        logic wcol;
        logic full;
    } flags_t;

    // System cycles per serial half period for a rate code.
    function automatic int unsigned half_cycles(input logic [1:0] rate);
        return 32'd2 << (2 * rate);
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int           W    = 3,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= INIT[i];
                stab_q <= INIT[i];
            end else begin
                meta_q <= d[i];
                stab_q <= meta_q;
            end
        end
        assign q[i] = stab_q;
    end

endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen
    import spi_port_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    assign limit = DIV_W'(half_cycles(rate) - 1);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
    parameter int DW = 8,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          abort,
    input  logic          tick,
    input  logic          out_lead,
    input  logic          late_smp,
    input  logic [CW-1:0] done_at,
    input  logic          sdi,
    output logic          sdo,
    output logic [CW-1:0] count,
    output logic          flip,
    output logic          done,
    output logic [DW-1:0] rx_word
);

    localparam int EDGES = 2 * DW;

    logic [DW-1:0] tx_q;
    logic [DW-1:0] rx_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] nxt;
    logic          do_shift;
    logic          do_sample;

    assign nxt = cnt_q + 1'b1;

    // Tick index nxt decides shift and sample from the phase offsets.
    always_comb begin
        int so;
        int ss;
        so        = int'(nxt) - int'(out_lead);
        ss        = so - int'(late_smp);
        do_shift  = tick && (so >= 2) && (so <= EDGES - 2) && ((so % 2) == 0);
        do_sample = tick && (ss >= 1) && (ss <= EDGES - 1) && ((ss % 2) == 1);
    end

    assign rx_word = do_sample ? {rx_q[DW-2:0], sdi} : rx_q;
    assign done    = tick && (nxt == done_at);
    assign flip    = tick && (int'(nxt) <= EDGES);
    assign sdo     = tx_q[DW-1];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            rx_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (load) begin
                tx_q <= load_data;
            end else if (do_shift) begin
                tx_q <= {tx_q[DW-2:0], 1'b0};
            end
            rx_q <= rx_word;
            if (abort || load) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= done ? '0 : nxt;
            end
        end
    end

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe
);

    localparam int EDGES = 2 * DW;
    localparam int CW    = $clog2(EDGES + 2);

    ctrl_t         ctrl_q;
    flags_t        flag_q;
    logic [DW-1:0] rxbuf_q;
    logic          run_q;
    logic          sck_q;
    logic          sck_prev_q;

    logic [2:0]    pins_s;
    logic          sck_s, ss_s, sdi_s;
    logic          sel_ok, slave_edge, div_tick, tick;
    logic          busy, cnt_nz, abort;
    logic          wr_data, rd_data, wr_ctrl, wr_stat, load, collide;
    logic          clr_wcol, clr_irq;
    logic          late_eff, sdi_eff, flip, done, sdo_w;
    logic [CW-1:0] done_at, count;
    logic [DW-1:0] rx_word;

    spi_sync #(.W(3), .INIT(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sdi_i, ss_n_i, sck_i}),
        .q   (pins_s)
    );

    assign sck_s = pins_s[0];
    assign ss_s  = pins_s[1];
    assign sdi_s = pins_s[2];

    spi_clkgen u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.master && run_q),
        .rate (ctrl_q.rate),
        .tick (div_tick)
    );

    // Slave edges count only while selected.
    assign sel_ok     = !ctrl_q.sel_en || !ss_s;
    assign slave_edge = !ctrl_q.master && sel_ok && (sck_s != sck_prev_q);
    assign tick       = ctrl_q.master ? div_tick : slave_edge;
    assign abort      = !ctrl_q.master && !sel_ok;

    assign cnt_nz = (count != '0);
    assign busy   = ctrl_q.master ? run_q : cnt_nz;

    assign wr_data  = bus_wr && (bus_addr == RA_DATA);
    assign wr_ctrl  = bus_wr && (bus_addr == RA_CTRL);
    assign wr_stat  = bus_wr && (bus_addr == RA_STAT);
    assign rd_data  = bus_rd && (bus_addr == RA_DATA);
    assign load     = wr_data && !busy;
    assign collide  = wr_data && busy;
    assign clr_wcol = wr_stat && bus_wdata[1];
    assign clr_irq  = wr_stat && bus_wdata[2];

    assign late_eff = ctrl_q.master && ctrl_q.late_smp;
    assign sdi_eff  = ctrl_q.master ? sdi_i : sdi_s;
    assign done_at  = CW'(EDGES) + CW'(ctrl_q.master && ctrl_q.out_lead && ctrl_q.late_smp);

    spi_shift #(.DW(DW), .CW(CW)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (bus_wdata),
        .abort     (abort),
        .tick      (tick),
        .out_lead  (ctrl_q.out_lead),
        .late_smp  (late_eff),
        .done_at   (done_at),
        .sdi       (sdi_eff),
        .sdo       (sdo_w),
        .count     (count),
        .flip      (flip),
        .done      (done),
        .rx_word   (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            run_q      <= 1'b0;
            sck_q      <= 1'b0;
            sck_prev_q <= 1'b0;
        end else begin
            sck_prev_q <= sck_s;
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            end
            if (!ctrl_q.master) begin
                run_q <= 1'b0;
            end else if (load) begin
                run_q <= 1'b1;
            end else if (done) begin
                run_q <= 1'b0;
            end
            if (!ctrl_q.master || !run_q) begin
                sck_q <= ctrl_q.cpol;
            end else if (flip) begin
                sck_q <= ~sck_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= '0;
            rxbuf_q <= '0;
        end else begin
            if (done) begin
                rxbuf_q     <= rx_word;
                flag_q.full <= 1'b1;
            end else if (rd_data) begin
                flag_q.full <= 1'b0;
            end
            if (done) begin
                flag_q.irq <= 1'b1;
            end else if (clr_irq) begin
                flag_q.irq <= 1'b0;
            end
            if (collide) begin
                flag_q.wcol <= 1'b1;
            end else if (clr_wcol) begin
                flag_q.wcol <= 1'b0;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            RA_DATA: bus_rdata = rxbuf_q;
            RA_CTRL: bus_rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
            RA_STAT: bus_rdata = {{(DW-4){1'b0}}, busy, flag_q.irq, flag_q.wcol, flag_q.full};
            default: bus_rdata = '0;
        endcase
    end

    assign irq    = flag_q.irq;
    assign sck_o  = sck_q;
    assign sck_oe = ctrl_q.master;
    assign sdo_o  = sdo_w;
    assign sdo_oe = ctrl_q.master || sel_ok;

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
    input logic clk,
    input logic rst,
    input logic wr_data,
    input logic rd_data,
    input logic clr_wcol,
    input logic busy,
    input logic done,
    input logic full,
    input logic wcol,
    input logic irq,
    input logic abort,
    input logic cnt_nz
);

    // R5
    full_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (full && irq));

    // R6
    rd_clears_full_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !done) |=> !full);

    // R7
    collide_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_data && busy) |=> wcol);

    // R7
    collide_keeps_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_data && busy && !done && !abort) |=> busy);

    // R8
    wcol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (wcol && !clr_wcol) |=> wcol);

    // R11
    deselect_resets_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> !cnt_nz);

endmodule

bind spi_port spi_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .clr_wcol (clr_wcol),
    .busy     (busy),
    .done     (done),
    .full     (flag_q.full),
    .wcol     (flag_q.wcol),
    .irq      (flag_q.irq),
    .abort    (abort),
    .cnt_nz   (cnt_nz)
);

// File: tb/spi_port_test.sv
module spi_port_test;
    import spi_port_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd2;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq, sck_o, sck_oe, sdo_o, sdo_oe;
    logic       sck_i = 1'b0;
    logic       ss_n_i = 1'b1;
    logic       sdi_i = 1'b0;

    int compared   = 0;
    int mismatched = 0;

    always #5 clk = ~clk;

    spi_port uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .sck_o     (sck_o),
        .sck_oe    (sck_oe),
        .sck_i     (sck_i),
        .ss_n_i    (ss_n_i),
        .sdi_i     (sdi_i),
        .sdo_o     (sdo_o),
        .sdo_oe    (sdo_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Returns at the falling edge right after the write edge.
    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_addr = 2'd2;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic data_rd_clear(output logic [7:0] v);
        @(negedge clk);
        bus_addr = 2'd0;
        bus_rd   = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
        bus_addr = 2'd2;
    endtask

    // Master transfer with the bench acting as the peer on sdi_i.
    task automatic run_master(input bit cpol, input bit cpha, input bit smp,
                              input logic [1:0] rate, input logic [7:0] tx,
                              input logic [7:0] peer, input bit collide);
        int half;
        int done_n;
        int tog;
        int t;
        int s;
        int k;
        logic [7:0] st;
        logic [7:0] v;
        string tag;
        tag    = cpha ? "R3" : (smp ? "R4" : "R1");
        half   = 2 << (2 * rate);
        done_n = (16 + ((cpha && smp) ? 1 : 0)) * half;
        reg_wr(2'd1, {1'b0, 1'b0, rate, smp, cpha, cpol, 1'b1});
        sdi_i = peer[7];
        reg_wr(2'd0, tx);
        for (int n = 0; n <= done_n; n++) begin
            if (n > 0) @(negedge clk);
            bus_wr   = 1'b0;
            bus_addr = 2'd2;
            tog = n / half;
            if (tog > 16) tog = 16;
            check("R2 sck level", sck_o, cpol ^ (tog % 2));
            #1 st = bus_rdata;
            if (n < done_n) check("R5 busy", st[3], 1);
            if (collide && n == done_n / 2 + 1) check("R7 collision flag", st[1], 1);
            if (((n + 1) % half) == 0) begin
                t = (n + 1) / half;
                s = t - int'(cpha) - int'(smp);
                if (s >= 1 && s <= 15 && (s % 2) == 1) begin
                    k = (s - 1) / 2;
                    check({tag, " sdo bit"}, sdo_o, tx[7-k]);
                end
            end
            s = tog - int'(cpha) - int'(smp);
            k = (s < 0) ? 0 : s / 2;
            if (k > 7) k = 7;
            sdi_i = peer[7-k];
            if (collide && n == done_n / 2) begin
                bus_addr  = 2'd0;
                bus_wdata = ~tx;
                bus_wr    = 1'b1;
            end
        end
        check("R5 full at completion", st[0], 1);
        check("R5 irq flag", st[2], 1);
        check("R5 irq pin", irq, 1);
        check("R5 busy cleared", st[3], 0);
        check("R7 R8 collision state", st[1], collide ? 1 : 0);
        reg_rd(2'd0, v);
        check({tag, " received byte"}, v, peer);
    endtask

    task automatic slave_byte(input int h, input logic [7:0] rx, input logic [7:0] tx,
                              input bit chk_tx);
        for (int k = 0; k < 8; k++) begin
            sdi_i = rx[7-k];
            repeat (h) @(negedge clk);
            if (chk_tx) check("R10 slave sdo bit", sdo_o, tx[7-k]);
            sck_i = 1'b1;
            repeat (h) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        reg_rd(2'd2, v);
        check("R5 reset status", v, 0);
        check("R5 reset irq", irq, 0);
        check("R10 reset sck_oe", sck_oe, 0);
        check("R2 reset sck", sck_o, 0);

        run_master(1'b0, 1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C, 1'b0);
        data_rd_clear(v);
        check("R1 read data", v, 8'h3C);
        reg_rd(2'd2, v);
        check("R6 full cleared by read", v[0], 0);
        reg_wr(2'd2, 8'h04);
        check("R8 irq cleared", irq, 0);

        run_master(1'b0, 1'b1, 1'b0, 2'd0, 8'h81, 8'h7E, 1'b0);
        run_master(1'b1, 1'b0, 1'b1, 2'd0, 8'hC3, 8'h96, 1'b0);
        reg_rd(2'd2, v);
        check("R9 no collision on full start", v[1], 0);
        reg_rd(2'd0, v);
        check("R9 newest byte kept", v, 8'h96);

        run_master(1'b1, 1'b1, 1'b1, 2'd1, 8'h5A, 8'hE1, 1'b1);
        repeat (3) @(negedge clk);
        reg_rd(2'd2, v);
        check("R8 collision sticky", v[1], 1);
        reg_wr(2'd2, 8'h02);
        reg_rd(2'd2, v);
        check("R8 collision cleared", v[1], 0);

        run_master(1'b0, 1'b0, 1'b0, 2'd2, 8'h0F, 8'hF0, 1'b0);
        run_master(1'b1, 1'b1, 1'b0, 2'd3, 8'h69, 8'h18, 1'b0);
        data_rd_clear(v);

        reg_wr(2'd1, 8'h40);
        sck_i  = 1'b0;
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        check("R11 deselected sdo_oe", sdo_oe, 0);
        check("R10 slave sck_oe", sck_oe, 0);
        reg_wr(2'd0, 8'hB7);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R11 selected sdo_oe", sdo_oe, 1);
        slave_byte(8, 8'h4D, 8'hB7, 1'b1);
        reg_rd(2'd2, v);
        check("R10 slave full", v[0], 1);
        data_rd_clear(v);
        check("R10 slave received", v, 8'h4D);

        sdi_i = 1'b1;
        repeat (8) @(negedge clk);
        sck_i = 1'b1;
        repeat (8) @(negedge clk);
        sck_i = 1'b0;
        repeat (8) @(negedge clk);
        sck_i = 1'b1;
        repeat (8) @(negedge clk);
        ss_n_i = 1'b1;
        sck_i  = 1'b0;
        repeat (5) @(negedge clk);
        check("R11 aborted sdo_oe", sdo_oe, 0);
        reg_rd(2'd2, v);
        check("R11 aborted busy", v[3], 0);
        reg_wr(2'd0, 8'h2E);
        reg_rd(2'd2, v);
        check("R11 write accepted", v[1], 0);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        slave_byte(8, 8'hD2, 8'h2E, 1'b1);
        data_rd_clear(v);
        check("R11 byte after abort", v, 8'hD2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule